// File: doc/BRIEF.md
# I2C master status flags and interrupt request logic

This block keeps the status state of an I2C master and turns it into two interrupt request lines. A separate bus engine reports what happens on the wire as single-cycle pulses: start condition sent, address acknowledged, byte finished, transmit holding empty, receive holding full, missing acknowledge, arbitration lost and bus error. It also supplies a level that is high while the bus is in use. Each pulse sets a sticky flag. Software reads the flags through a small register window and clears them by access sequences, not by writing ones.

Event flags and error flags drive separate request lines. Three enable bits in a control register gate them. The buffer flags (transmit empty, receive full) reach the event line only when a separate buffer enable is also set. This lets software service address and byte-finished events without taking a request for every byte.

Register offsets: control 1 at 0x00 (no state is kept here), control 2 at 0x04, data at 0x10, status 1 at 0x14, status 2 at 0x18. Reads return data combinationally from the stored state during the strobe cycle.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset every flag and every enable bit is 0, both request lines are low, and reads of status 1 and control 2 return 0.
- R2: A pulse on an engine input sets its flag, and the flag is visible from the next cycle. Status 1 bit positions: start-sent 0, address-done 1, byte-done 2, receive-full 6, transmit-empty 7, bus-error 8, arbitration-lost 9, ack-fail 10. All other bits read 0.
- R3: Status 2 bit 1 follows the bus-busy input level and its other bits read 0. Writes to status 2 have no effect.
- R4: Control 2 holds the error enable in bit 8, the event enable in bit 9 and the buffer enable in bit 10. They read back as written, and all other bits read 0.
- R5: irq_event is high exactly when the event enable is set and either (start-sent, address-done or byte-done) is set, or (the buffer enable is set and transmit-empty or receive-full is set).
- R6: irq_error is high exactly when the error enable is set and any of ack-fail, arbitration-lost or bus-error is set.
- R7: Address-done is cleared by a status 2 read that follows a status 1 read made while the flag was set. A status 2 read without that earlier status 1 read leaves the flag set.
- R8: Start-sent is cleared by a data register write that follows a status 1 read made while the flag was set. A data write without that read leaves the flag set.
- R9: Byte-done is cleared by a data register read or write that follows a status 1 read made while the flag was set. Otherwise data accesses leave it set.
- R10: A data register write clears transmit-empty. A data register read clears receive-full.
- R11: A status 1 write clears each error flag whose bit is written 0 and leaves it unchanged where the bit is written 1. Such a write does not change the event or buffer flags.
- R12: When a set pulse and a clearing access reach the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start_sent | input | 1 | Pulse: start condition sent |
| ev_addr_done | input | 1 | Pulse: address phase acknowledged |
| ev_byte_done | input | 1 | Pulse: byte transfer finished |
| ev_tx_empty | input | 1 | Pulse: transmit holding register empty |
| ev_rx_full | input | 1 | Pulse: receive holding register full |
| ev_ack_fail | input | 1 | Pulse: acknowledge missing |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_bus_err | input | 1 | Pulse: misplaced start or stop seen |
| bus_busy | input | 1 | Level: bus in use |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| irq_event | output | 1 | Event interrupt request |
| irq_error | output | 1 | Error interrupt request |

## Verification
The assertions assume that reg_rd and reg_wr are never high together. They also assume that the engine pulses last one cycle, so a set pulse seen at an edge describes one event. The bench drives every access through a single one-cycle task that raises at most one strobe. It changes inputs only on the falling edge, so each pulse or strobe spans exactly one rising edge. The collision cases of R12 place the pulse and the clearing access in that same cycle on purpose.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int NUM_FLAGS = 8;
  // internal flag order
  localparam int F_SB   = 0;
  localparam int F_ADDR = 1;
  localparam int F_BTF  = 2;
  localparam int F_TXE  = 3;
  localparam int F_RXNE = 4;
  localparam int F_AF   = 5;
  localparam int F_ARLO = 6;
  localparam int F_BERR = 7;

  localparam logic [4:0] OFS_CTL1  = 5'h00;
  localparam logic [4:0] OFS_CTL2  = 5'h04;
  localparam logic [4:0] OFS_DATA  = 5'h10;
  localparam logic [4:0] OFS_STAT1 = 5'h14;
  localparam logic [4:0] OFS_STAT2 = 5'h18;

  localparam int EN_ERR_BIT = 8;
  localparam int EN_EVT_BIT = 9;
  localparam int EN_BUF_BIT = 10;
  localparam int BUSY_BIT   = 1;

  // bit position of an internal flag inside status 1
  function automatic int stat1_pos(input int f);
    case (f)
      F_SB:    return 0;
      F_ADDR:  return 1;
      F_BTF:   return 2;
      F_TXE:   return 7;
      F_RXNE:  return 6;
      F_AF:    return 10;
      F_ARLO:  return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] pack_stat1(input logic [NUM_FLAGS-1:0] f);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < NUM_FLAGS; i++) w[stat1_pos(i)] = f[i];
    return w;
  endfunction

  function automatic logic evt_request(input logic [NUM_FLAGS-1:0] f,
                                       input logic en_evt, input logic en_buf);
    return en_evt & (f[F_SB] | f[F_ADDR] | f[F_BTF] |
                     (en_buf & (f[F_TXE] | f[F_RXNE])));
  endfunction

  function automatic logic err_request(input logic [NUM_FLAGS-1:0] f,
                                       input logic en_err);
    return en_err & (f[F_AF] | f[F_ARLO] | f[F_BERR]);
  endfunction
endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  a_r12_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
endmodule

// File: rtl/i2c_seq_arm.sv
module i2c_seq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic stat_rd_i,
  input  logic consume_i,
  output logic armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    armed_o <= 1'b0;
    else if (consume_i)            armed_o <= 1'b0;
    else if (stat_rd_i && flag_i)  armed_o <= 1'b1;
  end

  // arming is only meaningful while the guarded flag is up
  a_r7_arm_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |-> flag_i);
endmodule

// File: rtl/i2c_irq_gen.sv
module i2c_irq_gen
  import i2c_stat_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 en_evt_i,
  input  logic                 en_buf_i,
  input  logic                 en_err_i,
  output logic                 irq_evt_o,
  output logic                 irq_err_o
);
  always_comb begin
    irq_evt_o = evt_request(flags_i, en_evt_i, en_buf_i);
    irq_err_o = err_request(flags_i, en_err_i);
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start_sent,
  input  logic          ev_addr_done,
  input  logic          ev_byte_done,
  input  logic          ev_tx_empty,
  input  logic          ev_rx_full,
  input  logic          ev_ack_fail,
  input  logic          ev_arb_lost,
  input  logic          ev_bus_err,
  input  logic          bus_busy,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_event,
  output logic          irq_error
);
  localparam int NUM_ARMS = 3;

  logic [NUM_FLAGS-1:0] set_v, clr_v, flags;
  logic [NUM_ARMS-1:0]  arm_v, consume_v;
  logic en_err, en_evt, en_buf;

  // named access events
  logic sel_ctl2, sel_data, sel_st1, sel_st2;
  logic st1_rd, st1_wr, st2_rd, dat_rd, dat_wr, ctl2_wr;

  assign sel_ctl2 = (reg_addr == AW'(OFS_CTL2));
  assign sel_data = (reg_addr == AW'(OFS_DATA));
  assign sel_st1  = (reg_addr == AW'(OFS_STAT1));
  assign sel_st2  = (reg_addr == AW'(OFS_STAT2));
  assign st1_rd   = reg_rd & sel_st1;
  assign st1_wr   = reg_wr & sel_st1;
  assign st2_rd   = reg_rd & sel_st2;
  assign dat_rd   = reg_rd & sel_data;
  assign dat_wr   = reg_wr & sel_data;
  assign ctl2_wr  = reg_wr & sel_ctl2;

  assign set_v = {ev_bus_err, ev_arb_lost, ev_ack_fail, ev_rx_full,
                  ev_tx_empty, ev_byte_done, ev_addr_done, ev_start_sent};

  // sequence-clear consumers: 0 = start-sent, 1 = address, 2 = byte-done
  assign consume_v[0] = dat_wr & arm_v[0];
  assign consume_v[1] = st2_rd & arm_v[1];
  assign consume_v[2] = (dat_rd | dat_wr) & arm_v[2];

  always_comb begin
    clr_v         = '0;
    clr_v[F_SB]   = consume_v[0];
    clr_v[F_ADDR] = consume_v[1];
    clr_v[F_BTF]  = consume_v[2];
    clr_v[F_TXE]  = dat_wr;
    clr_v[F_RXNE] = dat_rd;
    clr_v[F_AF]   = st1_wr & ~reg_wdata[stat1_pos(F_AF)];
    clr_v[F_ARLO] = st1_wr & ~reg_wdata[stat1_pos(F_ARLO)];
    clr_v[F_BERR] = st1_wr & ~reg_wdata[stat1_pos(F_BERR)];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    i2c_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]),
      .flag_o(flags[i])
    );
  end

  for (genvar k = 0; k < NUM_ARMS; k++) begin : g_arm
    localparam int FI = (k == 0) ? F_SB : (k == 1) ? F_ADDR : F_BTF;
    i2c_seq_arm u_arm (
      .clk(clk), .rst_n(rst_n), .flag_i(flags[FI]), .stat_rd_i(st1_rd),
      .consume_i(consume_v[k]), .armed_o(arm_v[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_err <= 1'b0;
      en_evt <= 1'b0;
      en_buf <= 1'b0;
    end else if (ctl2_wr) begin
      en_err <= reg_wdata[EN_ERR_BIT];
      en_evt <= reg_wdata[EN_EVT_BIT];
      en_buf <= reg_wdata[EN_BUF_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_st1) begin
      reg_rdata = DW'(pack_stat1(flags));
    end else if (sel_st2) begin
      reg_rdata[BUSY_BIT] = bus_busy;
    end else if (sel_ctl2) begin
      reg_rdata[EN_ERR_BIT] = en_err;
      reg_rdata[EN_EVT_BIT] = en_evt;
      reg_rdata[EN_BUF_BIT] = en_buf;
    end
  end

  i2c_irq_gen u_irq (
    .flags_i(flags), .en_evt_i(en_evt), .en_buf_i(en_buf), .en_err_i(en_err),
    .irq_evt_o(irq_event), .irq_err_o(irq_error)
  );

  a_r5_event_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_evt |-> !irq_event);
  a_r6_error_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_err |-> !irq_error);
  a_r7_addr_sequence_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st2_rd && arm_v[1] && !ev_addr_done) |=> !flags[F_ADDR]);
  a_r8_sb_sequence_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && arm_v[0] && !ev_start_sent) |=> !flags[F_SB]);
  a_r11_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (st1_wr && flags[F_AF] && reg_wdata[stat1_pos(F_AF)]) |=> flags[F_AF]);
  a_r11_event_flags_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (st1_wr && flags[F_ADDR]) |=> flags[F_ADDR]);
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
endmodule

// File: tb/i2c_stat_irq_tb_top.sv
module i2c_stat_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev = '0;   // 0 sb,1 addr,2 btf,3 txe,4 rxne,5 af,6 arlo,7 berr
  logic busy = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq_e, irq_x;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [4:0] A_CTL2 = 5'h04, A_DATA = 5'h10, A_ST1 = 5'h14, A_ST2 = 5'h18;

  always #10 clk = ~clk;

  i2c_stat_irq dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_start_sent(ev[0]), .ev_addr_done(ev[1]), .ev_byte_done(ev[2]),
    .ev_tx_empty(ev[3]), .ev_rx_full(ev[4]), .ev_ack_fail(ev[5]),
    .ev_arb_lost(ev[6]), .ev_bus_err(ev[7]), .bus_busy(busy),
    .reg_rd(rd), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_event(irq_e), .irq_error(irq_x)
  );

  // status 1 bit for a bench pulse index (R2)
  function automatic int spos(input int p);
    int t[8] = '{0, 1, 2, 7, 6, 10, 9, 8};
    return t[p];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: optional strobe and pulses together; q = read data in that cycle
  task automatic cyc(input bit r, input bit w, input logic [4:0] a,
                     input logic [15:0] d, input logic [7:0] p,
                     output logic [15:0] q);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d; ev = p;
    #2 q = rdata;
    @(posedge clk);
    #1 rd = 0; wr = 0; ev = '0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] q);
    cyc(1, 0, a, '0, '0, q);
  endtask
  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] q;
    cyc(0, 1, a, d, '0, q);
  endtask
  task automatic pulse(input logic [7:0] p);
    logic [15:0] q;
    cyc(0, 0, 5'h0, '0, p, q);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; busy = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [15:0] q;
    do_reset();
    rd_reg(A_ST1, q); chk("R1 stat1", q, 16'h0);
    rd_reg(A_CTL2, q); chk("R1 ctl2", q, 16'h0);
    chk("R1 irqs", {14'h0, irq_e, irq_x}, 16'h0);
  endtask

  task automatic t_layout();
    logic [15:0] q;
    for (int p = 0; p < 8; p++) begin
      do_reset();
      pulse(8'(1 << p));
      rd_reg(A_ST1, q); chk($sformatf("R2 flag %0d", p), q, 16'(1 << spos(p)));
    end
    do_reset();
    pulse(8'hFF);
    rd_reg(A_ST1, q); chk("R2 all", q, 16'h07C7);
  endtask

  task automatic t_busy();
    logic [15:0] q;
    do_reset();
    busy = 1;
    rd_reg(A_ST2, q); chk("R3 busy high", q, 16'h0002);
    wr_reg(A_ST2, 16'hFFFF);
    busy = 0;
    rd_reg(A_ST2, q); chk("R3 write ignored", q, 16'h0000);
  endtask

  task automatic t_ctl();
    logic [15:0] q;
    do_reset();
    wr_reg(A_CTL2, 16'hFFFF);
    rd_reg(A_CTL2, q); chk("R4 all ones", q, 16'h0700);
    wr_reg(A_CTL2, 16'h0200);
    rd_reg(A_CTL2, q); chk("R4 evt only", q, 16'h0200);
  endtask

  task automatic t_evt_irq();
    do_reset();
    wr_reg(A_CTL2, 16'h0200);
    pulse(8'h08);                       // transmit empty
    #2 chk("R5 buf gated", {15'h0, irq_e}, 16'h0);
    wr_reg(A_CTL2, 16'h0600);
    #2 chk("R5 buf enabled", {15'h0, irq_e}, 16'h1);
    wr_reg(A_CTL2, 16'h0400);
    #2 chk("R5 evt off", {15'h0, irq_e}, 16'h0);
    do_reset();
    wr_reg(A_CTL2, 16'h0200);
    pulse(8'h04);                       // byte done
    #2 chk("R5 btf", {15'h0, irq_e}, 16'h1);
    chk("R6 no err irq", {15'h0, irq_x}, 16'h0);
  endtask

  task automatic t_err_irq();
    do_reset();
    pulse(8'h20);
    #2 chk("R6 disabled", {15'h0, irq_x}, 16'h0);
    wr_reg(A_CTL2, 16'h0100);
    #2 chk("R6 enabled", {15'h0, irq_x}, 16'h1);
    chk("R5 event low", {15'h0, irq_e}, 16'h0);
    wr_reg(A_ST1, 16'h0000);
    #2 chk("R6 cleared", {15'h0, irq_x}, 16'h0);
  endtask

  task automatic t_addr();
    logic [15:0] q;
    do_reset();
    pulse(8'h02);
    rd_reg(A_ST2, q);
    rd_reg(A_ST1, q); chk("R7 no prior read", q, 16'h0002);
    rd_reg(A_ST2, q);
    rd_reg(A_ST1, q); chk("R7 sequence clears", q, 16'h0000);
  endtask

  task automatic t_sb();
    logic [15:0] q;
    do_reset();
    pulse(8'h01);
    wr_reg(A_DATA, 16'h00A5);
    rd_reg(A_ST1, q); chk("R8 no prior read", q, 16'h0001);
    wr_reg(A_DATA, 16'h00A5);
    rd_reg(A_ST1, q); chk("R8 sequence clears", q, 16'h0000);
  endtask

  task automatic t_btf();
    logic [15:0] q;
    do_reset();
    pulse(8'h04);
    rd_reg(A_DATA, q);
    rd_reg(A_ST1, q); chk("R9 armed by read", q, 16'h0004);
    rd_reg(A_DATA, q);
    rd_reg(A_ST1, q); chk("R9 data read clears", q, 16'h0000);
  endtask

  task automatic t_txrx();
    logic [15:0] q;
    do_reset();
    pulse(8'h18);
    rd_reg(A_DATA, q);
    rd_reg(A_ST1, q); chk("R10 read clears rx", q, 16'h0080);
    wr_reg(A_DATA, 16'h0011);
    rd_reg(A_ST1, q); chk("R10 write clears tx", q, 16'h0000);
  endtask

  task automatic t_err_clr();
    logic [15:0] q;
    do_reset();
    pulse(8'hE3);                       // sb, addr, af, arlo, berr
    wr_reg(A_ST1, 16'h0300);
    rd_reg(A_ST1, q); chk("R11 af cleared only", q, 16'h0303);
    wr_reg(A_ST1, 16'h0000);
    rd_reg(A_ST1, q); chk("R11 events kept", q, 16'h0003);
  endtask

  task automatic t_collide();
    logic [15:0] q;
    do_reset();
    pulse(8'h80);
    cyc(0, 1, A_ST1, 16'h0000, 8'h80, q);
    rd_reg(A_ST1, q); chk("R12 error set wins", q, 16'h0100);
    do_reset();
    pulse(8'h02);
    rd_reg(A_ST1, q);
    cyc(1, 0, A_ST2, '0, 8'h02, q);
    rd_reg(A_ST1, q); chk("R12 addr set wins", q, 16'h0002);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_layout();
    t_busy();
    t_ctl();
    t_evt_irq();
    t_err_irq();
    t_addr();
    t_sb();
    t_btf();
    t_txrx();
    t_err_clr();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule